// File: doc/BRIEF.md
# Multi-channel down-counting timer

This block is a memory-mapped timer with `NCH` independent down-counters, each `CW` bits wide. Each channel has three registers. A control register picks the tick source and holds the reload, load-on-write, interrupt-enable and interrupt-flag bits. A preset register holds the value used for reloads. A read-only register shows the live count. A global control register can freeze every channel at once. A read-only identity register reports the major revision. Software uses one channel as a programmable one-shot event timer. It uses another as a free-running timestamp with a preset of all ones, and inverts the count it reads to get a value that counts up.

The register port is a plain single-cycle interface. A write takes effect at the clock edge where `bus_wr` is high. Read data is registered: `bus_rdata` shows, after edge k, the value the addressed register held just before edge k. The control and global registers each have two write aliases, at +0x4 and +0x8. The first ORs in the written ones and the second clears them, so one bit can change without a read-modify-write. The slow tick arrives as a one-clock enable pulse from outside.

Top module: `cdtimer`

## Requirements
- R1: After reset, every control, count, preset and global register reads 0 and `irq` is 0.
- R2: A channel's count falls by exactly one on each tick. Tick-select field [3:0] = 0xF ticks every clock, 0xB ticks only when `slow_tick` is high, and every other value, including 0, never ticks. A count that is not zero never rises on a tick.
- R3: A tick that finds the count at zero, with the reload bit (bit 6) set, copies the preset into the count and sets the flag (bit 15). With a preset of all ones, the count therefore steps 0 → 0xFFFFFFFF.
- R4: With the load-on-write bit (bit 7) set, a write to the preset register also loads the count at once and arms the channel. An armed channel that ticks at zero without reload sets the flag, stays at zero and stops flagging on later ticks.
- R5: With bit 7 clear, a preset write changes only the preset and leaves the count unchanged.
- R6: Control-register fields sit at [3:0] select, bit 6 reload, bit 7 load-on-write, bit 14 interrupt enable and bit 15 flag. Every other bit reads as 0.
- R7: A write to base+0x4 ORs the written ones into a control or global register. A write to base+0x8 clears them. A read from either alias returns the base register. A flag set by a tick persists until software clears it.
- R8: `irq` is the OR over channels of flag AND enable, registered, so it follows that product one clock later. A flag with its enable clear never raises `irq`.
- R9: The identity register at 0x20 + NCH·0x40 reads 0x0200_0000 (major revision 2 in [31:24]). Writes to it are ignored.
- R10: Channel n's registers sit at 0x20 + n·0x40 (control), 0x30 + n·0x40 (count) and 0x40 + n·0x40 (preset). Writes to the count address are ignored.
- R11: Global register bit 0 at 0x00 freezes all channels: while it is 1, no count moves.
- R12: Read data appears one clock after the address. Unmapped or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-clock enable pulse from the slow tick source |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Registered OR of enabled channel flags |

## Verification
A wrong count shows on the count register at the next read. Because reads are registered, the value seen lags the state by one clock. A wrong select decode shows after one sweep window as a count that differs from the arithmetic tick total for that select value. A corrupted flag or enable shows on `irq` exactly one clock after the fault, and on the control readback one clock after the address. An armed or reload state that is wrong only shows at the next tick at zero: as a missed wrap, a flag that should not appear, or a one-shot that keeps counting.

// File: rtl/cdtimer_pkg.sv
`timescale 1ns/1ps
package cdtimer_pkg;
  localparam logic [3:0] SEL_SLOW  = 4'hB;
  localparam logic [3:0] SEL_EVERY = 4'hF;

  localparam int B_RELOAD = 6;
  localparam int B_UPDATE = 7;
  localparam int B_IEN    = 14;
  localparam int B_FLAG   = 15;
  localparam int B_FREEZE = 0;

  localparam logic [31:0] CTRL_MASK = 32'h0000_C0CF;
  localparam logic [31:0] GLOB_MASK = 32'h0000_0001;
  localparam logic [7:0]  MAJOR_REV = 8'd2;

  localparam int CTRL0  = 32'h20;
  localparam int CNT0   = 32'h30;
  localparam int FIX0   = 32'h40;
  localparam int STRIDE = 32'h40;

  typedef enum logic [1:0] {
    ACC_BASE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_NONE = 2'd3
  } acc_e;

  function automatic logic [31:0] apply_acc(acc_e a, logic [31:0] cur,
                                            logic [31:0] wd, logic [31:0] mask);
    case (a)
      ACC_BASE: return wd & mask;
      ACC_SET:  return (cur | wd) & mask;
      ACC_CLR:  return cur & ~wd & mask;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/cdtimer_dec.sv
`timescale 1ns/1ps
module cdtimer_dec
  import cdtimer_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 12
) (
  input  logic [AW-1:0]  addr,
  output acc_e           acc,
  output logic           glob_hit,
  output logic           ver_hit,
  output logic [NCH-1:0] ctrl_hit,
  output logic [NCH-1:0] cnt_hit,
  output logic [NCH-1:0] fix_hit
);
  localparam int VER_OFS = CTRL0 + NCH * STRIDE;

  logic [AW-1:0] slot;
  logic          word_ok;
  logic          alias_ok;

  assign slot     = {addr[AW-1:4], 4'h0};
  assign word_ok  = (addr[1:0] == 2'b00);
  assign acc      = acc_e'(addr[3:2]);
  assign alias_ok = (addr[3:2] != 2'd3);
  assign glob_hit = word_ok && alias_ok && (slot == '0);
  assign ver_hit  = (addr == AW'(VER_OFS));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ctrl_hit[n] = word_ok && alias_ok && (slot == AW'(CTRL0 + n * STRIDE));
    assign cnt_hit[n]  = (addr == AW'(CNT0 + n * STRIDE));
    assign fix_hit[n]  = (addr == AW'(FIX0 + n * STRIDE));
  end
endmodule

// File: rtl/cdtimer_chan.sv
`timescale 1ns/1ps
module cdtimer_chan
  import cdtimer_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slow_tick,
  input  logic          freeze,
  input  logic          ctrl_wr,
  input  acc_e          acc,
  input  logic          fix_wr,
  input  logic [31:0]   wdata,
  output logic [31:0]   ctrl_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] fix_q,
  output logic          irq_req
);
  logic        tick;
  logic        armed_q;
  logic        hit_zero;
  logic [31:0] ctrl_nx;

  always_comb begin
    case (ctrl_q[3:0])
      SEL_EVERY: tick = 1'b1;
      SEL_SLOW:  tick = slow_tick;
      default:   tick = 1'b0;
    endcase
    if (freeze) tick = 1'b0;
  end

  assign hit_zero = tick && (cnt_q == '0) && (ctrl_q[B_RELOAD] || armed_q);

  always_comb begin
    ctrl_nx = ctrl_wr ? apply_acc(acc, ctrl_q, wdata, CTRL_MASK) : ctrl_q;
    if (hit_zero) ctrl_nx[B_FLAG] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      fix_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nx;
      if (fix_wr) fix_q <= wdata[CW-1:0];
      if (fix_wr && ctrl_q[B_UPDATE]) begin
        cnt_q   <= wdata[CW-1:0];
        armed_q <= 1'b1;
      end else if (hit_zero) begin
        cnt_q   <= ctrl_q[B_RELOAD] ? fix_q : '0;
        armed_q <= 1'b0;
      end else if (tick && (cnt_q != '0)) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign irq_req = ctrl_q[B_FLAG] & ctrl_q[B_IEN];
endmodule

// File: rtl/cdtimer.sv
`timescale 1ns/1ps
module cdtimer
  import cdtimer_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 32,
  parameter int AW  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slow_tick,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  acc_e                     acc;
  logic                     glob_hit;
  logic                     ver_hit;
  logic [NCH-1:0]           ctrl_hit;
  logic [NCH-1:0]           cnt_hit;
  logic [NCH-1:0]           fix_hit;
  logic [31:0]              glob_q;
  logic [NCH-1:0][31:0]     ctrl_a;
  logic [NCH-1:0][CW-1:0]   cnt_a;
  logic [NCH-1:0][CW-1:0]   fix_a;
  logic [NCH-1:0]           req_v;
  logic [31:0]              rd_mux;

  cdtimer_dec #(.NCH(NCH), .AW(AW)) dec_i (
    .addr(bus_addr), .acc(acc), .glob_hit(glob_hit), .ver_hit(ver_hit),
    .ctrl_hit(ctrl_hit), .cnt_hit(cnt_hit), .fix_hit(fix_hit)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    cdtimer_chan #(.CW(CW)) chan_i (
      .clk(clk), .rst(rst), .slow_tick(slow_tick), .freeze(glob_q[B_FREEZE]),
      .ctrl_wr(bus_wr && ctrl_hit[n]), .acc(acc),
      .fix_wr(bus_wr && fix_hit[n]), .wdata(bus_wdata),
      .ctrl_q(ctrl_a[n]), .cnt_q(cnt_a[n]), .fix_q(fix_a[n]), .irq_req(req_v[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) glob_q <= '0;
    else if (bus_wr && glob_hit) glob_q <= apply_acc(acc, glob_q, bus_wdata, GLOB_MASK);
  end

  always_comb begin
    rd_mux = '0;
    if (glob_hit) rd_mux = glob_q;
    if (ver_hit)  rd_mux = {MAJOR_REV, 24'h0};
    for (int n = 0; n < NCH; n++) begin
      if (ctrl_hit[n]) rd_mux = ctrl_a[n];
      if (cnt_hit[n])  rd_mux = 32'(cnt_a[n]);
      if (fix_hit[n])  rd_mux = 32'(fix_a[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq       <= |req_v;
    end
  end
endmodule

// File: rtl/cdtimer_chk.sv
`timescale 1ns/1ps
module cdtimer_chk #(
  parameter int NCH = 2,
  parameter int CW  = 32,
  parameter int AW  = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_wr,
  input logic [31:0]            bus_rdata,
  input logic                   irq,
  input logic [31:0]            glob_q,
  input logic [NCH-1:0][31:0]   ctrl_a,
  input logic [NCH-1:0][CW-1:0] cnt_a
);
  localparam logic [AW-1:0] VER_A = AW'(32'h20 + NCH * 32'h40);

  logic any_ien;
  always_comb begin
    any_ien = 1'b0;
    for (int n = 0; n < NCH; n++) any_ien |= ctrl_a[n][14];
  end

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(any_ien));

  // R9
  ver_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == VER_A) |=> (bus_rdata == 32'h0200_0000));

  for (genvar n = 0; n < NCH; n++) begin : g_c
    // R2
    dec_one_chk: assert property (@(posedge clk) disable iff (rst)
      (!bus_wr && !glob_q[0] && ctrl_a[n][3:0] == 4'hF && cnt_a[n] != '0)
      |=> (cnt_a[n] == $past(cnt_a[n]) - CW'(1)));

    // R4
    stop_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!bus_wr && cnt_a[n] == '0 && !ctrl_a[n][6]) |=> (cnt_a[n] == '0));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!bus_wr && ctrl_a[n][15]) |=> ctrl_a[n][15]);

    // R11
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (!bus_wr && glob_q[0]) |=> $stable(cnt_a[n]));
  end
endmodule

bind cdtimer cdtimer_chk #(.NCH(NCH), .CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .irq(irq), .glob_q(glob_q),
  .ctrl_a(ctrl_a), .cnt_a(cnt_a)
);

// File: tb/cdtimer_tb_top.sv
`timescale 1ns/1ps
module cdtimer_tb_top;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slow_tick = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cdtimer #(.NCH(2), .CW(32), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // All tasks start and end just after a falling edge; each consumes rising edges as named.
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a[AW-1:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    bus_addr = a[AW-1:0]; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse(input int k);
    repeat (k) begin
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
    end
  endtask

  task automatic expect_rd(input string req, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    expect_rd("R1 glob",  32'h00, 32'h0);
    expect_rd("R1 ctrl0", 32'h20, 32'h0);
    expect_rd("R1 cnt0",  32'h30, 32'h0);
    expect_rd("R1 fix0",  32'h40, 32'h0);
    expect_rd("R1 ctrl1", 32'h60, 32'h0);
    expect_rd("R1 cnt1",  32'h70, 32'h0);
    expect_rd("R1 fix1",  32'h80, 32'h0);
    expect_rd("R9 version", 32'hA0, 32'h0200_0000);

    // R6 field layout, R8 irq follows flag&enable one clock later
    wr(32'h20, 32'hFFFF_FFFF);
    expect_rd("R6 ctrl mask", 32'h20, 32'h0000_C0CF);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    wr(32'h20, 32'h0);
    idle(1);
    check("R8 irq dropped", {31'b0, irq}, 32'h0);

    // R7 set/clear aliases
    wr(32'h20, 32'h0000_4000);
    wr(32'h24, 32'h0000_0040);
    expect_rd("R7 base after set", 32'h20, 32'h0000_4040);
    expect_rd("R7 read set alias", 32'h24, 32'h0000_4040);
    expect_rd("R7 read clr alias", 32'h28, 32'h0000_4040);
    wr(32'h28, 32'h0000_4000);
    expect_rd("R7 after clr", 32'h20, 32'h0000_0040);
    wr(32'h28, 32'h0000_0040);
    expect_rd("R7 all clear", 32'h20, 32'h0);

    // R5 preset write without load bit; R4 one-shot
    wr(32'h20, 32'h0000_000B);
    wr(32'h40, 32'd5);
    expect_rd("R5 count untouched", 32'h30, 32'h0);
    expect_rd("R10 preset readback", 32'h40, 32'd5);
    wr(32'h24, 32'h0000_0080);
    wr(32'h40, 32'd3);
    expect_rd("R4 immediate load", 32'h30, 32'd3);
    pulse(3);
    expect_rd("R4 at zero no flag", 32'h20, 32'h0000_008B);
    pulse(1);
    expect_rd("R4 flag on zero tick", 32'h20, 32'h0000_808B);
    check("R8 flag without enable", {31'b0, irq}, 32'h0);
    wr(32'h28, 32'h0000_8000);
    pulse(2);
    expect_rd("R4 stopped no reflag", 32'h20, 32'h0000_008B);
    expect_rd("R4 stays zero", 32'h30, 32'h0);

    // R3 reload on zero tick
    wr(32'h20, 32'h0000_004B);
    wr(32'h40, 32'd2);
    expect_rd("R5 count kept", 32'h30, 32'h0);
    pulse(1);
    expect_rd("R3 reload value", 32'h30, 32'd2);
    expect_rd("R3 flag on reload", 32'h20, 32'h0000_804B);
    idle(3);
    expect_rd("R2 no slow tick no move", 32'h30, 32'd2);
    wr(32'h28, 32'h0000_8000);
    pulse(2);
    expect_rd("R3 no flag before zero", 32'h20, 32'h0000_004B);
    pulse(1);
    expect_rd("R3 second reload", 32'h30, 32'd2);
    wr(32'h20, 32'h0);

    // R3 free-running wrap, R12 read latency
    wr(32'h80, 32'hFFFF_FFFF);
    wr(32'h60, 32'h0000_004F);
    expect_rd("R12 pre-edge zero", 32'h70, 32'h0);
    expect_rd("R3 wrap to ones", 32'h70, 32'hFFFF_FFFF);
    expect_rd("R2 decrement after wrap", 32'h70, 32'hFFFF_FFFE);
    expect_rd("R3 wrap flag", 32'h60, 32'h0000_804F);
    wr(32'h60, 32'h0);

    // R11 freeze
    wr(32'h20, 32'h0000_0080);
    wr(32'h40, 32'd50);
    wr(32'h04, 32'h1);
    expect_rd("R11 global set", 32'h00, 32'h1);
    wr(32'h20, 32'h0000_008F);
    idle(5);
    expect_rd("R11 frozen", 32'h30, 32'd50);
    wr(32'h08, 32'h1);
    idle(3);
    wr(32'h20, 32'h0000_0080);
    expect_rd("R11 resumed", 32'h30, 32'd46);
    expect_rd("R11 global cleared", 32'h00, 32'h0);

    // R10 read-only count, R9 read-only identity
    wr(32'h30, 32'h0000_1234);
    expect_rd("R10 count write ignored", 32'h30, 32'd46);
    wr(32'hA0, 32'h0);
    expect_rd("R9 version write ignored", 32'hA0, 32'h0200_0000);

    // R12 unmapped
    expect_rd("R12 alias slot 3", 32'h2C, 32'h0);
    expect_rd("R12 hole", 32'h10, 32'h0);
    expect_rd("R12 misaligned", 32'h22, 32'h0);

    // R8 channel 1 interrupt path
    wr(32'h64, 32'h0000_C000);
    idle(1);
    check("R8 ch1 irq", {31'b0, irq}, 32'h1);
    wr(32'h68, 32'h0000_8000);
    idle(1);
    check("R8 ch1 irq cleared", {31'b0, irq}, 32'h0);

    // R2 exhaustive select sweep: 4 window clocks (2 slow pulses) plus the closing write
    for (int s = 0; s < 16; s++) begin
      logic [31:0] v;
      int exp_t;
      wr(32'h20, 32'h0000_0080);
      wr(32'h40, 32'd100);
      wr(32'h20, 32'h0000_0080 | s);
      pulse(1); idle(1); pulse(1); idle(1);
      wr(32'h20, 32'h0000_0080);
      exp_t = (s == 15) ? 5 : (s == 11) ? 2 : 0;
      rd(32'h30, v);
      check($sformatf("R2 select 0x%0h", s), v, 32'(100 - exp_t));
    end

    finish_run();
  end
endmodule